// File: doc/BRIEF.md
# Lockable Configurable GPIO Port

This block provides sixteen single-bit general-purpose pins behind a byte-wide host bus. Each pin has an output latch, a direction bit, a drive-type bit that selects push-pull or open-drain output, and a pull-up enable that applies while the pin is an input. The block does not model the pad. It hands a per-pin output value, output enable and pull-up enable to the pad ring and takes back a per-pin input level.

The ten byte registers sit at a base address held in a 16-bit register. A separate load strobe can move that base anywhere in the host address space. Each pin also has a lock bit. A host write can set it, and only reset clears it. While it is set, the pin's direction, drive type and pull-up cannot be changed. Writes to the output latch still take effect on locked pins.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an unlocked push-pull input with its pull-up off and its latch at 0, so `pin_oe` and `pin_pu` are all 0. `rdata` is 0 and the base equals `BASE_RESET`.
- R2: A host access hits only when `addr - base` lies in 0..9. The byte pairs are: +0/+1 output latch (pins 0-7, 8-15), +2/+3 direction (1 = output), +4/+5 drive type (1 = open-drain), +6/+7 pull-up (1 = enabled), +8/+9 lock (1 = locked). A write outside that window changes nothing, and a read outside it returns 0.
- R3: A `base_wr` pulse loads `base_wdata` as the new base, and it takes effect from the next cycle. A host access in the same cycle as `base_wr` decodes against the old base. The base holds its value when `base_wr` is low.
- R4: A pin with direction 1 and drive type 0 has `pin_oe` = 1 and `pin_out` = its latch.
- R5: A pin with drive type 1 has `pin_out` = 0. When its direction is 1, its `pin_oe` is the inverse of its latch.
- R6: A pin with direction 0 has `pin_oe` = 0. `pin_pu` is 1 only for a pin whose direction is 0 and whose pull-up bit is 1.
- R7: A read returns data on `rdata` one cycle after `rd`. In the latch byte, each bit shows `pin_in` for an input pin and the latch for an output pin. `rdata` is 0 in any cycle that follows a cycle without `rd`.
- R8: The direction, drive-type, pull-up and lock bytes read back the stored bit of each pin.
- R9: Writing 1 to a lock bit sets it. Writing 0 to a lock bit leaves it unchanged, and only reset clears it.
- R10: For a locked pin, writes to its direction, drive-type and pull-up bits are ignored. Unlocked pins in the same byte still update. Latch writes apply to all pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Load strobe for the base register |
| base_wdata | input | 16 | New base address |
| addr | input | 16 | Host byte address |
| wdata | input | 8 | Host write data |
| wr | input | 1 | Host write strobe |
| rd | input | 1 | Host read strobe |
| rdata | output | 8 | Read data, valid the cycle after `rd` |
| pin_in | input | 16 | Pin input levels, already synchronous to `clk` |
| pin_out | output | 16 | Per-pin output value |
| pin_oe | output | 16 | Per-pin output enable |
| pin_pu | output | 16 | Per-pin pull-up enable |

## Verification
Two events can fall in the same clock cycle: a base relocation and a host write. The bench provokes this by raising `base_wr` together with a write to the direction byte at the current base. It then judges the outcome from the ports alone. The direction byte must have changed when read at the new base, and the old base must no longer answer. A lock write and a later configuration write to the same byte are also interleaved. The bench judges them pin by pin against a shadow model that honours the lock.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the GPIO port: the register field codes.
// Field order matters: the address decoder maps offset/NB onto it.
package gpio_pkg;
    localparam int NFIELDS = 5;

    typedef enum logic [2:0] {
        FLD_DATA = 3'd0,
        FLD_DIR  = 3'd1,
        FLD_DRV  = 3'd2,
        FLD_PU   = 3'd3,
        FLD_LOCK = 3'd4
    } gpio_field_e;
endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
// Holds the relocatable base register and decodes a host address into
// a field and a byte lane. Assumes NB bytes per field. A hit is reported
// when addr - base falls inside the NFIELDS*NB register window. Decoding
// uses the registered base, so a same-cycle base load does not affect it.
module gpio_addr_decode #(
    parameter int                ADDR_W     = 16,
    parameter int                NB         = 2,
    parameter logic [ADDR_W-1:0] BASE_RESET = '0,
    localparam int               BS_W       = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  base_wr,
    input  logic [ADDR_W-1:0]     base_wdata,
    input  logic [ADDR_W-1:0]     addr,
    output logic [ADDR_W-1:0]     base_q,
    output logic                  hit,
    output gpio_pkg::gpio_field_e field,
    output logic [BS_W-1:0]       byte_sel
);
    logic [ADDR_W-1:0] offset;

    // Base register: loaded by the strobe, reset to the default window.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_RESET;
        else if (base_wr) base_q <= base_wdata;
    end

    assign offset = addr - base_q;

    // Window compare: each legal offset names one field and lane.
    always_comb begin
        hit      = 1'b0;
        field    = gpio_pkg::FLD_DATA;
        byte_sel = '0;
        for (int f = 0; f < gpio_pkg::NFIELDS; f++) begin
            for (int b = 0; b < NB; b++) begin
                if (offset == ADDR_W'(f * NB + b)) begin
                    hit      = 1'b1;
                    field    = gpio_pkg::gpio_field_e'(3'(f));
                    byte_sel = BS_W'(b);
                end
            end
        end
    end
endmodule

// File: rtl/gpio_pin_slice.sv
`timescale 1ns/1ps
// State and pad controls for one pin. Holds the latch, direction,
// drive type, pull-up and lock. The lock is sticky until reset and
// blocks configuration writes but not latch writes. Assumes pin_in
// is already synchronous.
module gpio_pin_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic wbit,
    input  logic data_we,
    input  logic dir_we,
    input  logic drv_we,
    input  logic pu_we,
    input  logic lock_we,
    input  logic pin_in,
    output logic dir_q,
    output logic drv_q,
    output logic pu_q,
    output logic lock_q,
    output logic rd_level,
    output logic pin_out,
    output logic pin_oe,
    output logic pin_pu
);
    logic lat_q;

    // Pin registers: latch always writable, configuration gated by lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= 1'b0;
            dir_q  <= 1'b0;
            drv_q  <= 1'b0;
            pu_q   <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (data_we)            lat_q  <= wbit;
            if (dir_we && !lock_q)  dir_q  <= wbit;
            if (drv_we && !lock_q)  drv_q  <= wbit;
            if (pu_we  && !lock_q)  pu_q   <= wbit;
            if (lock_we && wbit)    lock_q <= 1'b1;
        end
    end

    // Pad controls: open-drain only ever pulls low.
    always_comb begin
        pin_out  = lat_q & ~drv_q;
        pin_oe   = dir_q & (drv_q ? ~lat_q : 1'b1);
        pin_pu   = pu_q & ~dir_q;
        rd_level = dir_q ? lat_q : pin_in;
    end
endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
// Registered read path. Selects a field vector and a byte lane and
// presents it on rdata one cycle after rd. Returns 0 otherwise.
module gpio_read_mux #(
    parameter int  NPINS  = 16,
    parameter int  DATA_W = 8,
    parameter int  BS_W   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic                  hit,
    input  gpio_pkg::gpio_field_e field,
    input  logic [BS_W-1:0]       byte_sel,
    input  logic [NPINS-1:0]      lvl_v,
    input  logic [NPINS-1:0]      dir_v,
    input  logic [NPINS-1:0]      drv_v,
    input  logic [NPINS-1:0]      pu_v,
    input  logic [NPINS-1:0]      lock_v,
    output logic [DATA_W-1:0]     rdata
);
    logic [NPINS-1:0]  vec;
    logic [DATA_W-1:0] lane;

    // Field select followed by lane select.
    always_comb begin
        unique case (field)
            gpio_pkg::FLD_DIR:  vec = dir_v;
            gpio_pkg::FLD_DRV:  vec = drv_v;
            gpio_pkg::FLD_PU:   vec = pu_v;
            gpio_pkg::FLD_LOCK: vec = lock_v;
            default:            vec = lvl_v;
        endcase
        lane = vec[int'(byte_sel) * DATA_W +: DATA_W];
    end

    // Output register: zero unless a hitting read was presented.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (rd && hit)  rdata <= lane;
        else                 rdata <= '0;
    end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
// Lockable GPIO port top. Connects the decoder, one slice per pin and
// the read path. Assumes NPINS is a multiple of 8 and pin_in is
// synchronous to clk. A write and a read in one cycle are both honoured.
module gpio_port #(
    parameter int                NPINS      = 16,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_RESET = 16'h0480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [7:0]        rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu
);
    localparam int DATA_W = 8;
    localparam int NB     = NPINS / DATA_W;
    localparam int BS_W   = (NB > 1) ? $clog2(NB) : 1;

    logic [ADDR_W-1:0]     base_q;
    logic                  hit;
    gpio_pkg::gpio_field_e field;
    logic [BS_W-1:0]       byte_sel;
    logic [NB-1:0]         lane_we;
    logic [NPINS-1:0]      lvl_v, dir_q, drv_q, pu_q, lock_q;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .NB(NB), .BASE_RESET(BASE_RESET)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .addr(addr), .base_q(base_q), .hit(hit), .field(field),
        .byte_sel(byte_sel)
    );

    // Per-lane write enables, then one slice per pin.
    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign lane_we[l] = wr && hit && (byte_sel == BS_W'(l));
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int LANE = p / DATA_W;
        localparam int BIT  = p % DATA_W;
        gpio_pin_slice u_pin (
            .clk(clk), .rst_n(rst_n),
            .wbit(wdata[BIT]),
            .data_we(lane_we[LANE] && field == gpio_pkg::FLD_DATA),
            .dir_we (lane_we[LANE] && field == gpio_pkg::FLD_DIR),
            .drv_we (lane_we[LANE] && field == gpio_pkg::FLD_DRV),
            .pu_we  (lane_we[LANE] && field == gpio_pkg::FLD_PU),
            .lock_we(lane_we[LANE] && field == gpio_pkg::FLD_LOCK),
            .pin_in(pin_in[p]),
            .dir_q(dir_q[p]), .drv_q(drv_q[p]), .pu_q(pu_q[p]),
            .lock_q(lock_q[p]), .rd_level(lvl_v[p]),
            .pin_out(pin_out[p]), .pin_oe(pin_oe[p]), .pin_pu(pin_pu[p])
        );
    end

    gpio_read_mux #(
        .NPINS(NPINS), .DATA_W(DATA_W), .BS_W(BS_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(rd), .hit(hit), .field(field),
        .byte_sel(byte_sel), .lvl_v(lvl_v), .dir_v(dir_q), .drv_v(drv_q),
        .pu_v(pu_q), .lock_v(lock_q), .rdata(rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
// Property checker for gpio_port. It observes the ports and the per-pin
// configuration vectors and is attached through the bind below.
module gpio_port_chk #(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic              base_wr,
    input logic [7:0]        rdata,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_pu,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  drv_q,
    input logic [NPINS-1:0]  pu_q,
    input logic [NPINS-1:0]  lock_q,
    input logic [ADDR_W-1:0] base_q
);
    assert_base_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr |=> $stable(base_q));

    assert_pp_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~drv_q & ~pin_oe) == '0);

    assert_od_low_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & drv_q) == '0);

    assert_input_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_q) == '0);

    assert_pu_inputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & dir_q) == '0);

    assert_rdata_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == '0);

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) & ~lock_q) == '0);

    assert_locked_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) & ($past(dir_q) ^ dir_q)) == '0);

    assert_locked_drv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) & ($past(drv_q) ^ drv_q)) == '0);

    assert_locked_pu_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) & ($past(pu_q) ^ pu_q)) == '0);
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd(rd), .base_wr(base_wr), .rdata(rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .dir_q(dir_q),
    .drv_q(drv_q), .pu_q(pu_q), .lock_q(lock_q), .base_q(base_q)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
// Self-checking bench: a shadow model of the registers predicts pins
// and read-back over swept configurations, locks, relocation and reset.
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [15:0] base_wdata = '0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pin_pu;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    logic [15:0] m_lat, m_dir, m_drv, m_pu, m_lock, cur_base;

    always #2.5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .addr(addr), .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_total++;
        if (got === exp) n_pass++;
        else $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    endtask

    task automatic model_reset();
        m_lat = '0; m_dir = '0; m_drv = '0; m_pu = '0; m_lock = '0;
        cur_base = 16'h0480;
    endtask

    // Shadow of a register write at a window offset.
    task automatic model_write(int off, logic [7:0] d);
        int f = off / 2;
        int b = off % 2;
        for (int j = 0; j < 8; j++) begin
            int p = b * 8 + j;
            case (f)
                0: m_lat[p] = d[j];
                1: if (!m_lock[p]) m_dir[p] = d[j];
                2: if (!m_lock[p]) m_drv[p] = d[j];
                3: if (!m_lock[p]) m_pu[p]  = d[j];
                default: if (d[j]) m_lock[p] = 1'b1;
            endcase
        end
    endtask

    function automatic logic [7:0] model_read(int off);
        logic [15:0] v;
        case (off / 2)
            0: v = (m_dir & m_lat) | (~m_dir & pin_in);
            1: v = m_dir;
            2: v = m_drv;
            3: v = m_pu;
            default: v = m_lock;
        endcase
        return (off % 2) ? v[15:8] : v[7:0];
    endfunction

    task automatic host_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic host_rd(logic [15:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic reg_wr(int off, logic [7:0] d);
        host_wr(cur_base + 16'(off), d);
        model_write(off, d);
    endtask

    task automatic check_pins(string tag);
        chk(tag, "pin_oe",  pin_oe,  m_dir & (~m_drv | ~m_lat));
        chk(tag, "pin_out", pin_out, m_lat & ~m_drv);
        chk(tag, "pin_pu",  pin_pu,  m_pu & ~m_dir);
    endtask

    task automatic check_regs(string tag);
        logic [7:0] d;
        for (int off = 0; off < 10; off++) begin
            host_rd(cur_base + 16'(off), d);
            chk(tag, $sformatf("reg +%0d", off), d, model_read(off));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5.0);
        if (!done) begin
            n_total++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports and in every register.
        check_pins("R1");
        chk("R1", "rdata idle", rdata, 8'h00);
        check_regs("R1");

        // R4 R5 R6 R7 R8: uniform combos, then arithmetic patterns.
        for (int k = 0; k < 24; k++) begin
            logic [15:0] lat, dir, drv, pu;
            if (k < 8) begin
                lat = k[0] ? 16'hFFFF : 16'h0000;
                dir = k[1] ? 16'hFFFF : 16'h0000;
                drv = k[2] ? 16'hFFFF : 16'h0000;
                pu  = 16'hFFFF;
            end else begin
                lat = 16'(16'h3C5A + k * 16'h1357);
                dir = 16'hA5C3 ^ 16'(k * 16'h0F21);
                drv = 16'(16'h6996 + k * 16'h2468);
                pu  = ~lat ^ 16'(k * 16'h0101);
            end
            pin_in = 16'(16'h9E37 * (k + 1));
            reg_wr(0, lat[7:0]); reg_wr(1, lat[15:8]);
            reg_wr(2, dir[7:0]); reg_wr(3, dir[15:8]);
            reg_wr(4, drv[7:0]); reg_wr(5, drv[15:8]);
            reg_wr(6, pu[7:0]);  reg_wr(7, pu[15:8]);
            check_pins("R4_R5_R6");
            check_regs("R7_R8");
        end

        // R2: accesses just outside the window are ignored.
        host_rd(cur_base + 16'd10, d);
        chk("R2", "read +10", d, 8'h00);
        host_rd(cur_base - 16'd1, d);
        chk("R2", "read -1", d, 8'h00);
        host_wr(cur_base + 16'd10, 8'hFF);
        host_wr(cur_base - 16'd1, 8'hFF);
        host_wr(cur_base + 16'd16, 8'h5A);
        check_pins("R2");
        check_regs("R2");

        // R9 R10: lock a mixed mask, then try to move configuration.
        reg_wr(8, 8'h3C); reg_wr(9, 8'h0F);
        check_regs("R9");
        reg_wr(2, 8'hFF); reg_wr(3, 8'hFF);
        reg_wr(4, 8'hFF); reg_wr(5, 8'hFF);
        reg_wr(6, 8'hFF); reg_wr(7, 8'hFF);
        check_pins("R10");
        check_regs("R10");
        reg_wr(2, 8'h00); reg_wr(3, 8'h00);
        reg_wr(4, 8'h00); reg_wr(5, 8'h00);
        reg_wr(6, 8'h00); reg_wr(7, 8'h00);
        check_pins("R10");
        check_regs("R10");
        reg_wr(8, 8'h00); reg_wr(9, 8'h00);
        check_regs("R9");
        reg_wr(0, 8'hA5); reg_wr(1, 8'h5A);
        check_pins("R10");
        check_regs("R10");

        // R3: relocate, old window must go silent.
        @(negedge clk); base_wr = 1'b1; base_wdata = 16'h1230;
        @(negedge clk); base_wr = 1'b0;
        host_rd(16'h0480, d);
        chk("R3", "old base read", d, 8'h00);
        cur_base = 16'h1230;
        check_regs("R3");

        // R3: relocation and write in the same cycle use the old base.
        @(negedge clk);
        base_wr = 1'b1; base_wdata = 16'h2000;
        addr = 16'h1232; wdata = 8'hFF; wr = 1'b1;
        @(negedge clk);
        base_wr = 1'b0; wr = 1'b0;
        model_write(2, 8'hFF);
        host_rd(16'h1232, d);
        chk("R3", "previous base read", d, 8'h00);
        cur_base = 16'h2000;
        check_regs("R3");
        check_pins("R3");

        // R9 R1: reset clears locks and restores the base.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_pins("R1");
        check_regs("R1");
        reg_wr(2, 8'hFF); reg_wr(3, 8'hFF);
        check_regs("R9");
        check_pins("R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule